// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of up to 32 general-purpose pins, controlled through a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. Every access completes in the cycle it is presented, so the bus has no back-pressure and no valid/ready handshake. Each pin works in one of three ways:

- as a general input, read through a synchronised input register;
- as a general output, driven from an output data register;
- as an interrupt input.

In interrupt mode each pin can sense a level or an edge. It can be active-high or active-low (rising or falling for edges), and it can optionally respond to both edges. Edge events are latched in a pending register until software clears them by writing ones to a clear register. Level-sensed pins show their live condition instead.

A per-pin enable (mask) register decides which pending bits reach the single combined interrupt output. Enable bits are removed by writing zeros to the mask register, and are added by writing ones to a separate unmask register. A filter on/off register exists but only stores its value.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0 and `irq` is 0. Every pin is then a masked general input with nothing pending.
- R2: `pin_out` always equals the output data register (0x08). A `pin_oe` bit is 1 only when the direction bit (0x04, 1 = output) is 1 and the mode bit (0x00, 1 = interrupt) is 0.
- R3: The input data register (0x0C) returns `pin_in` through a two-flop synchroniser. A pin change is not visible after one clock and is visible after two.
- R4: An edge-sensed interrupt pin latches its pending bit (0x10) on the selected edge, three clocks after the pin change. Edge sensing is selected by a 1 in 0x24. The edge is rising when the polarity bit (0x20) is 0 and falling when it is 1; the other edge sets nothing.
- R5: With the both-edge bit (0x4C) set, an edge-sensed pin latches on rising and falling edges alike, and its polarity bit has no effect.
- R6: A level-sensed interrupt pin (0x24 bit = 0) shows a pending bit equal to the synchronised pin XOR its polarity bit. Writing its clear bit has no effect on it.
- R7: Writing 1 to a bit of the clear register (0x14) clears that pin's latched edge event. Bits written as 0 leave pending bits unchanged.
- R8: A write to the mask register (0x18) clears every enable bit written as 0 and keeps every bit written as 1. A write to the unmask register (0x1C) sets every enable bit written as 1.
- R9: `irq` is high exactly when some pin is both pending and enabled.
- R10: A pin in general I/O mode (0x00 bit = 0) never shows a pending bit, whatever its pin activity or sensing configuration.
- R11: The filter register (0x28) reads back what was written. The clear and unmask registers, and unmapped addresses, read 0.
- R12: When an edge event and a write of 1 to that pin's clear bit fall in the same clock, the event wins and the pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is a clear write that lands in the very clock in which a new edge is latched. Hitting it needs the pin change placed exactly three clock edges before the write takes effect. The stimulus drives the pin at a falling clock edge, waits two rising edges, and then presents the clear write so that it is sampled on the third. It then checks that the pending bit survived. A later isolated clear confirms that the same bit can still be cleared.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef logic [7:0] reg_addr_t;

  localparam reg_addr_t A_MODE   = 8'h00;
  localparam reg_addr_t A_DIR    = 8'h04;
  localparam reg_addr_t A_OUT    = 8'h08;
  localparam reg_addr_t A_IN     = 8'h0C;
  localparam reg_addr_t A_PEND   = 8'h10;
  localparam reg_addr_t A_CLR    = 8'h14;
  localparam reg_addr_t A_MASK   = 8'h18;
  localparam reg_addr_t A_UNMASK = 8'h1C;
  localparam reg_addr_t A_POL    = 8'h20;
  localparam reg_addr_t A_EDGE   = 8'h24;
  localparam reg_addr_t A_FILT   = 8'h28;
  localparam reg_addr_t A_BOTH   = 8'h4C;

  typedef struct packed {
    logic [31:0] mode;
    logic [31:0] dir;
    logic [31:0] outd;
    logic [31:0] pol;
    logic [31:0] edg;
    logic [31:0] both;
    logic [31:0] filt;
    logic [31:0] mask;
  } bank_cfg_t;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  reg_addr_t   bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] in_word,
  input  logic [31:0] pend_word,
  output bank_cfg_t   cfg,
  output logic [31:0] clr_pulse
);
  localparam logic [31:0] LANES = 32'((64'd1 << NPINS) - 64'd1);

  logic [31:0] wd;
  assign wd = bus_wdata & LANES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_MODE:   cfg.mode <= wd;
        A_DIR:    cfg.dir  <= wd;
        A_OUT:    cfg.outd <= wd;
        A_POL:    cfg.pol  <= wd;
        A_EDGE:   cfg.edg  <= wd;
        A_BOTH:   cfg.both <= wd;
        A_FILT:   cfg.filt <= bus_wdata;
        A_MASK:   cfg.mask <= cfg.mask & wd;
        A_UNMASK: cfg.mask <= cfg.mask | wd;
        default:  ;
      endcase
    end
  end

  assign clr_pulse = (bus_we && bus_addr == A_CLR) ? wd : '0;

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = cfg.mode;
      A_DIR:   bus_rdata = cfg.dir;
      A_OUT:   bus_rdata = cfg.outd;
      A_IN:    bus_rdata = in_word;
      A_PEND:  bus_rdata = pend_word;
      A_MASK:  bus_rdata = cfg.mask;
      A_POL:   bus_rdata = cfg.pol;
      A_EDGE:  bus_rdata = cfg.edg;
      A_FILT:  bus_rdata = cfg.filt;
      A_BOTH:  bus_rdata = cfg.both;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_pin_irq.sv
module gpio_bank_pin_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic mode_irq,
  input  logic edge_sel,
  input  logic pol_low,
  input  logic both_sel,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic latch_q;
  logic rise, fall, evt;

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
  assign evt  = mode_irq & edge_sel &
                (both_sel ? (rise | fall) : (pol_low ? fall : rise));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= lvl;
      latch_q <= evt | (latch_q & ~clr);
    end
  end

  assign pend = mode_irq & (edge_sel ? latch_q : (lvl ^ pol_low));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  bank_cfg_t        cfg_q;
  logic [31:0]      clr_pulse;
  logic [NPINS-1:0] sync_q;
  logic [31:0]      in_word;
  logic [31:0]      pend_vec;
  logic [31:0]      cfg_mask, cfg_mode, cfg_dir;

  gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  always_comb begin
    in_word = '0;
    in_word[NPINS-1:0] = sync_q;
  end

  gpio_bank_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_word(in_word),
    .pend_word(pend_vec), .cfg(cfg_q), .clr_pulse(clr_pulse)
  );

  for (genvar p = 0; p < 32; p++) begin : g_pin
    if (p < NPINS) begin : g_live
      gpio_bank_pin_irq u_det (
        .clk(clk), .rst_n(rst_n), .lvl(sync_q[p]),
        .mode_irq(cfg_q.mode[p]), .edge_sel(cfg_q.edg[p]),
        .pol_low(cfg_q.pol[p]), .both_sel(cfg_q.both[p]),
        .clr(clr_pulse[p]), .pend(pend_vec[p])
      );
    end else begin : g_none
      assign pend_vec[p] = 1'b0;
    end
  end

  assign cfg_mask = cfg_q.mask;
  assign cfg_mode = cfg_q.mode;
  assign cfg_dir  = cfg_q.dir;

  assign pin_out = cfg_q.outd[NPINS-1:0];
  assign pin_oe  = cfg_q.dir[NPINS-1:0] & ~cfg_q.mode[NPINS-1:0];
  assign irq     = |(pend_vec & cfg_q.mask);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_addr,
  input logic             bus_we,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      mask,
  input logic [31:0]      mode,
  input logic [31:0]      dir,
  input logic [31:0]      pend,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq
);
  // R1: interrupt quiet on leaving reset
  p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);

  // R2: output enable only for pins chosen as outputs
  p_oe_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(pin_oe) & ~dir) == 32'd0));

  // R8: mask write only removes enables
  p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h18) |=>
      ((mask & ~$past(bus_wdata)) == 32'd0) && ((mask & ~$past(mask)) == 32'd0));

  // R8: unmask write sets every written one
  p_unmask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h1C) |=>
      (($past(bus_wdata) & 32'((64'd1 << NPINS) - 64'd1) & ~mask) == 32'd0));

  // R9: no interrupt without an enabled pin
  p_irq_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != 32'd0) && (pend != 32'd0));

  // R10: general-mode pins never pending
  p_general_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~mode) == 32'd0));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .mask(cfg_mask), .mode(cfg_mode), .dir(cfg_dir),
  .pend(pend_vec), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          irq;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.NPINS(NP)) i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cleanup();
    pin_in = '0; tick(3);
    wr(8'h00, 0); wr(8'h24, 0); wr(8'h20, 0); wr(8'h4C, 0);
    wr(8'h18, 0); wr(8'h14, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 mode", v, 0);
    rd(8'h04, v); chk("R1 dir", v, 0);
    rd(8'h08, v); chk("R1 out", v, 0);
    rd(8'h10, v); chk("R1 pend", v, 0);
    rd(8'h18, v); chk("R1 mask", v, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_direction();
    wr(8'h08, 32'h0000_00A5); wr(8'h04, 32'h0000_000F);
    chk("R2 pin_out", pin_out, 32'hA5);
    chk("R2 pin_oe", pin_oe, 32'h0F);
    wr(8'h00, 32'h1);
    chk("R2 oe int mode", pin_oe, 32'h0E);
    wr(8'h00, 0); wr(8'h04, 0);
    chk("R2 oe off", pin_oe, 0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    pin_in = 32'h1234_5678;
    tick(1); rd(8'h0C, v); chk("R3 one clock", v, 0);
    tick(1); rd(8'h0C, v); chk("R3 two clocks", v, 32'h1234_5678);
    cleanup();
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(8'h00, 32'h3); wr(8'h24, 32'h3); wr(8'h20, 32'h2);
    pin_in = 32'h3;
    tick(2); rd(8'h10, v); chk("R4 not yet", v, 0);
    tick(1); rd(8'h10, v); chk("R4 rise only pin0", v, 32'h1);
    pin_in = 32'h1;
    tick(3); rd(8'h10, v); chk("R4 fall pin1", v, 32'h3);
    chk("R9 masked irq low", {31'd0, irq}, 0);
    wr(8'h1C, 32'h2);
    chk("R9 irq high", {31'd0, irq}, 1);
    wr(8'h14, 32'h0);
    rd(8'h10, v); chk("R7 zero clear no effect", v, 32'h3);
    wr(8'h14, 32'h2);
    rd(8'h10, v); chk("R7 clear pin1", v, 32'h1);
    chk("R9 irq low after clear", {31'd0, irq}, 0);
    cleanup();
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(8'h1C, 32'hFF);
    rd(8'h18, v); chk("R8 unmask", v, 32'hFF);
    wr(8'h18, 32'hFFFF_FFFB);
    rd(8'h18, v); chk("R8 mask one pin", v, 32'hFB);
    wr(8'h1C, 32'h0);
    rd(8'h18, v); chk("R8 unmask zero no effect", v, 32'hFB);
    wr(8'h18, 32'h0);
    rd(8'h18, v); chk("R8 mask all", v, 0);
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(8'h00, 32'h4); wr(8'h24, 32'h4); wr(8'h4C, 32'h4); wr(8'h20, 32'h4);
    pin_in = 32'h4;
    tick(3); rd(8'h10, v); chk("R5 rise", v, 32'h4);
    wr(8'h14, 32'h4);
    rd(8'h10, v); chk("R5 cleared", v, 0);
    pin_in = 32'h0;
    tick(3); rd(8'h10, v); chk("R5 fall", v, 32'h4);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(8'h00, 32'h8);
    rd(8'h10, v); chk("R6 low idle", v, 0);
    pin_in = 32'h8;
    tick(2); rd(8'h10, v); chk("R6 high level", v, 32'h8);
    wr(8'h14, 32'h8);
    rd(8'h10, v); chk("R6 clear ignored", v, 32'h8);
    pin_in = 32'h0;
    tick(2); rd(8'h10, v); chk("R6 follows low", v, 0);
    wr(8'h20, 32'h8);
    rd(8'h10, v); chk("R6 active low", v, 32'h8);
    wr(8'h1C, 32'h8);
    chk("R9 level irq", {31'd0, irq}, 1);
    cleanup();
  endtask

  task automatic t_general();
    logic [31:0] v;
    wr(8'h24, 32'h10); wr(8'h20, 32'h20); wr(8'h1C, 32'h30);
    pin_in = 32'h10;
    tick(3); rd(8'h10, v); chk("R10 no edge pend", v, 0);
    pin_in = 32'h0;
    tick(3); rd(8'h10, v); chk("R10 no level pend", v, 0);
    chk("R10 irq low", {31'd0, irq}, 0);
    cleanup();
  endtask

  task automatic t_filter();
    logic [31:0] v;
    wr(8'h28, 32'hDEAD_BEEF);
    rd(8'h28, v); chk("R11 filter", v, 32'hDEAD_BEEF);
    rd(8'h14, v); chk("R11 clear reads 0", v, 0);
    wr(8'h1C, 32'h1);
    rd(8'h1C, v); chk("R11 unmask reads 0", v, 0);
    rd(8'h30, v); chk("R11 unmapped", v, 0);
    wr(8'h18, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(8'h00, 32'h20); wr(8'h24, 32'h20);
    pin_in = 32'h20;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_addr = 8'h14; bus_wdata = 32'h20; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    rd(8'h10, v); chk("R12 event wins", v, 32'h20);
    wr(8'h14, 32'h20);
    rd(8'h10, v); chk("R7 later clear", v, 0);
    cleanup();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_direction();
    t_input();
    t_edge();
    t_mask();
    t_both();
    t_level();
    t_general();
    t_filter();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule